// File: doc/BRIEF.md
# Single-Level I/O Page Translator

This block sits between a PCI-side DMA master and the system memory fabric. It turns each incoming bus address into a system physical page address. Work is done in 4 KiB pages, and one 64-bit directory entry per page is held in system memory. A programmable base/mask pair, with an enable bit, picks which addresses take part in translation. Every other address comes back as its own page address.

For an address that matches, the block does the following in order:
- it works out where the directory entry sits;
- it issues one 64-bit read on its memory request port;
- it checks the entry's valid flag;
- it answers with either the physical page address or a fault.

Only one lookup is in flight at a time. Requests use a valid/ready handshake, and each result comes back as a one-cycle response pulse. Five 64-bit configuration registers can be accessed with 64-bit or 32-bit writes and reads.

Top module: `iova_xlate`

## Requirements
- R1: After reset, all five configuration registers read zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The registers sit at these byte offsets on `cfg_addr`:
  - 0x300: range base (bit 0 is the enable)
  - 0x308: range mask
  - 0x310: purge
  - 0x318: table config
  - 0x320: directory base

  A 64-bit access (`cfg_wide`=1) writes or reads the whole register. Offsets outside 0x300..0x327 read zero and ignore writes.
- R3: With `cfg_wide`=0, `cfg_addr` bit 2 selects the upper (1) or lower (0) 32-bit half. A write takes `cfg_wdata[31:0]` into that half only. A read returns that half in `cfg_rdata[31:0]` with bits 63:32 zero.
- R4: When range-base bit 0 is 0, the response returns `req_addr` with bits 11:0 cleared and `rsp_fault`=0. No memory read is issued, and `rsp_valid` rises in the cycle after the request is accepted.
- R5: When the range is enabled but `(page address & mask)` differs from the range base with bit 0 cleared, the lookup bypasses exactly as in R4.
- R6: A matching lookup issues one memory read at `directory_base + (req_addr >> 12) * 8`, computed modulo 2^64. `mem_req_valid` holds, with a stable address, until `mem_req_ready`.
- R7: If bit 63 of the returned entry (`mem_rsp_data`) is 1, the response is that entry with bit 63 and bits 11:0 cleared, and `rsp_fault`=0.
- R8: If bit 63 of the returned entry is 0, the response has `rsp_fault`=1 and `rsp_addr`=0.
- R9: `req_ready` is 0 from acceptance until the response pulse ends. `rsp_valid` is never high for two cycles in a row. `req_ready` returns to 1 in the cycle after the pulse.
- R10: The match decision and entry address use the register values at acceptance. A register write during an outstanding lookup does not change that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit half access |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Combinational read data for `cfg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Bus-side address to translate |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_addr | output | 64 | Physical page address (zero on fault) |
| rsp_fault | output | 1 | Directory entry was not valid |
| mem_req_valid | output | 1 | Directory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Directory entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Directory entry, little-endian 64-bit word |

## Verification
The bound checker watches, on every cycle, the properties that can be seen at the ports or at the registers:
- the busy interval keeps `req_ready` low;
- the response pulse lasts one cycle;
- a memory request stays stable until it is taken;
- a memory request happens only inside a lookup;
- no read is issued while the range was disabled at acceptance;
- results are page-aligned;
- faults carry a zero address;
- fetched results have bit 63 cleared.

Only the bench scenarios can show whether a result is the right one:
- the directory entry address, including wrap-around;
- match and mismatch against random base/mask settings;
- half-register writes;
- a configuration write landing in the middle of a lookup.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned CFG_NREGS = 5;

    // Register slot order follows the offset map (one 8-byte slot each)
    localparam int unsigned REG_BASE  = 0;
    localparam int unsigned REG_MASK  = 1;
    localparam int unsigned REG_PURGE = 2;
    localparam int unsigned REG_TCFG  = 3;
    localparam int unsigned REG_DIR   = 4;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FETCH = 2'd1,
        WALK_WAIT  = 2'd2,
        WALK_DONE  = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [CFG_NREGS-1:0][WORD_W-1:0] r;
    } cfg_state_t;

    typedef struct packed {
        walk_state_e       state;
        logic [WORD_W-1:0] addr;   // entry address while fetching, result when done
        logic              fault;
    } walk_t;

endpackage

// File: rtl/iox_cfg_regs.sv
module iox_cfg_regs
    import iox_pkg::*;
#(
    parameter int unsigned    AW       = 12,
    parameter logic [AW-1:0]  BASE_OFF = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wide,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] base_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] dir_o
);
    localparam int unsigned   IW      = $clog2(CFG_NREGS);
    localparam int unsigned   HALF    = WORD_W / 2;
    localparam logic [AW-1:0] END_OFF = BASE_OFF + AW'(CFG_NREGS * 8);

    cfg_state_t        st_d, st_q;
    logic [AW-1:0]     off;
    logic [IW-1:0]     idx;
    logic              in_map;
    logic [WORD_W-1:0] word;

    always_comb begin
        off    = addr - BASE_OFF;
        idx    = IW'(off >> 3);
        in_map = (addr >= BASE_OFF) && (addr < END_OFF);
        st_d   = st_q;
        word   = '0;
        for (int g = 0; g < CFG_NREGS; g++) begin
            if (in_map && idx == IW'(g)) begin
                word = st_q.r[g];
                if (we) begin
                    if (wide) begin
                        st_d.r[g] = wdata;
                    end else if (addr[2]) begin
                        st_d.r[g][WORD_W-1:HALF] = wdata[HALF-1:0];
                    end else begin
                        st_d.r[g][HALF-1:0] = wdata[HALF-1:0];
                    end
                end
            end
        end
        if (wide) begin
            rdata = word;
        end else begin
            rdata = {{HALF{1'b0}}, (addr[2] ? word[WORD_W-1:HALF] : word[HALF-1:0])};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.r[REG_BASE];
    assign mask_o = st_q.r[REG_MASK];
    assign dir_o  = st_q.r[REG_DIR];

endmodule

// File: rtl/iox_range_match.sv
module iox_range_match
    import iox_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned PTE_SHIFT  = 3
) (
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [WORD_W-1:0] dir_i,
    output logic [WORD_W-1:0] page_o,
    output logic [WORD_W-1:0] pte_o,
    output logic              hit_o
);
    localparam logic [WORD_W-1:0] OFF_MASK = (WORD_W'(1) << PAGE_SHIFT) - WORD_W'(1);

    always_comb begin
        page_o = req_addr & ~OFF_MASK;
        hit_o  = base_i[0] && ((page_o & mask_i) == (base_i & ~WORD_W'(1)));
        pte_o  = dir_i + ((page_o >> PAGE_SHIFT) << PTE_SHIFT);
    end

endmodule

// File: rtl/iox_walk_fsm.sv
module iox_walk_fsm
    import iox_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] page_i,
    input  logic [WORD_W-1:0] pte_i,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_addr,
    output logic              rsp_fault
);
    localparam int unsigned VALID_BIT = WORD_W - 1;

    walk_t             w_d, w_q;
    logic [WORD_W-1:0] ent;

    always_comb begin
        w_d = w_q;
        ent = mem_rsp_data;
        ent[VALID_BIT] = 1'b0;
        ent[PAGE_SHIFT-1:0] = '0;
        case (w_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    w_d.fault = 1'b0;
                    if (hit_i) begin
                        w_d.state = WALK_FETCH;
                        w_d.addr  = pte_i;
                    end else begin
                        w_d.state = WALK_DONE;
                        w_d.addr  = page_i;
                    end
                end
            end
            WALK_FETCH: begin
                if (mem_req_ready) begin
                    w_d.state = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.state = WALK_DONE;
                    if (mem_rsp_data[VALID_BIT]) begin
                        w_d.addr  = ent;
                        w_d.fault = 1'b0;
                    end else begin
                        w_d.addr  = '0;
                        w_d.fault = 1'b1;
                    end
                end
            end
            default: begin
                w_d.state = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign req_ready     = (w_q.state == WALK_IDLE);
    assign mem_req_valid = (w_q.state == WALK_FETCH);
    assign mem_req_addr  = w_q.addr;
    assign rsp_valid     = (w_q.state == WALK_DONE);
    assign rsp_addr      = w_q.addr;
    assign rsp_fault     = w_q.fault;

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
    import iox_pkg::*;
#(
    parameter int unsigned       CFG_AW       = 12,
    parameter logic [CFG_AW-1:0] CFG_BASE_OFF = 12'h300,
    parameter int unsigned       PAGE_SHIFT   = 12,
    parameter int unsigned       PTE_BYTES    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_wide,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES);

    logic [WORD_W-1:0] cfg_base, cfg_mask, cfg_dir;
    logic [WORD_W-1:0] page_addr, pte_addr;
    logic              range_hit;

    iox_cfg_regs #(
        .AW       (CFG_AW),
        .BASE_OFF (CFG_BASE_OFF)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wide   (cfg_wide),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .base_o (cfg_base),
        .mask_o (cfg_mask),
        .dir_o  (cfg_dir)
    );

    iox_range_match #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .PTE_SHIFT  (PTE_SHIFT)
    ) u_match (
        .req_addr (req_addr),
        .base_i   (cfg_base),
        .mask_i   (cfg_mask),
        .dir_i    (cfg_dir),
        .page_o   (page_addr),
        .pte_o    (pte_addr),
        .hit_o    (range_hit)
    );

    iox_walk_fsm #(
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .hit_i         (range_hit),
        .page_i        (page_addr),
        .pte_i         (pte_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_addr      (rsp_addr),
        .rsp_fault     (rsp_fault)
    );

endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk #(
    parameter int unsigned PAGE_SHIFT = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [63:0] rsp_addr,
    input logic        rsp_fault,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        base_en
);
    localparam logic [63:0] OFF_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

    logic busy_q, byp_q, fetched_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            byp_q     <= 1'b0;
            fetched_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            busy_q    <= 1'b1;
            byp_q     <= !base_en;
            fetched_q <= 1'b0;
        end else begin
            if (rsp_valid) busy_q <= 1'b0;
            if (mem_req_valid && mem_req_ready) fetched_q <= 1'b1;
        end
    end

    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !req_ready);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6
    mem_in_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy_q);

    // R4
    bypass_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && byp_q) |-> !mem_req_valid);

    // R7
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_addr & OFF_MASK) == 64'd0));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == 64'd0));

    // R7
    valid_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fetched_q && !rsp_fault) |-> !rsp_addr[63]);

endmodule

bind iova_xlate iova_xlate_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .base_en       (cfg_base[0])
);

// File: tb/iova_xlate_bench.sv
`timescale 1ns/1ps
module iova_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_wide = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0, cfg_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_addr;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    iova_xlate u_iova_xlate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wide(cfg_wide), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int          n_chk = 0, n_fail = 0;
    bit          done = 0;
    logic [63:0] sh [5];
    bit          use_ovr = 0;
    logic [63:0] ovr = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [63:0] a);
        if (use_ovr) return ovr;
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'hA5A5_0000_1234_5678;
    endfunction

    function automatic logic [63:0] exp_rd(input logic [11:0] a, input bit wide);
        logic [63:0] w;
        w = '0;
        if (a >= 12'h300 && a < 12'h328) w = sh[int'((a - 12'h300) >> 3)];
        if (wide) return w;
        return a[2] ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
    endfunction

    task automatic cfg_wr(input logic [11:0] a, input bit wide, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wide = wide; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (a >= 12'h300 && a < 12'h328) begin
            int k;
            k = int'((a - 12'h300) >> 3);
            if (wide) sh[k] = d;
            else if (a[2]) sh[k][63:32] = d[31:0];
            else sh[k][31:0] = d[31:0];
        end
    endtask

    task automatic cfg_rd(input logic [11:0] a, input bit wide, output logic [63:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wide = wide;
        #1 d = cfg_rdata;
    endtask

    task automatic set_reg(input int k, input logic [63:0] v);
        logic [11:0] o;
        o = 12'h300 + 12'(k * 8);
        if ($urandom % 2 == 0) cfg_wr(o, 1, v);
        else begin
            cfg_wr(o, 0, {32'h0, v[31:0]});
            cfg_wr(o | 12'h4, 0, {32'h0, v[63:32]});
        end
    endtask

    task automatic xlate(input logic [63:0] a, input string tag, input bit disturb);
        logic [63:0] pte, ent, exp_addr, got_addr, maddr;
        bit hit, exp_fault, got_fault, seen, got, ok_rdy;
        int lat, phase, dly, w;
        hit = sh[0][0] && (((a & ~64'hFFF) & sh[1]) == (sh[0] & ~64'h1));
        pte = sh[4] + ((a >> 12) << 3);
        ent = entry_of(pte);
        if (!hit) begin
            exp_addr = a & ~64'hFFF; exp_fault = 0;
        end else if (ent[63]) begin
            exp_addr = ent & ~64'h8000_0000_0000_0FFF; exp_fault = 0;
        end else begin
            exp_addr = 64'h0; exp_fault = 1;
        end
        @(negedge clk);
        req_valid = 1; req_addr = a;
        w = 0;
        while (!req_ready && w < 20) begin @(negedge clk); w++; end
        @(negedge clk);
        req_valid = 0;
        seen = 0; got = 0; ok_rdy = 1; phase = 0; dly = 0; lat = -1;
        maddr = '0; got_addr = '0; got_fault = 0;
        for (int c = 0; c < 60; c++) begin
            mem_rsp_valid = 0;
            if (disturb && c == 0) begin
                cfg_we = 1; cfg_addr = 12'h300; cfg_wide = 1; cfg_wdata = 64'h0;
            end
            if (disturb && c == 1) begin
                cfg_we = 0; sh[0] = 64'h0;
            end
            if (rsp_valid) begin
                got = 1; lat = c; got_addr = rsp_addr; got_fault = rsp_fault;
                break;
            end
            if (req_ready) ok_rdy = 0;
            case (phase)
                0: if (mem_req_valid) begin
                    if (!seen) begin seen = 1; maddr = mem_req_addr; end
                    if ($urandom % 3 != 0) begin mem_req_ready = 1; phase = 1; end
                end
                1: begin mem_req_ready = 0; dly = int'($urandom % 3); phase = 2; end
                2: if (dly == 0) begin
                    mem_rsp_valid = 1; mem_rsp_data = entry_of(maddr); phase = 3;
                end else dly--;
                default: ;
            endcase
            @(negedge clk);
        end
        mem_rsp_valid = 0; mem_req_ready = 0;
        if (cfg_we) begin @(negedge clk); cfg_we = 0; sh[0] = 64'h0; end
        check(got, tag, 64'(got), 64'd1);
        check(got_addr == exp_addr, tag, got_addr, exp_addr);
        check(got_fault == exp_fault, tag, 64'(got_fault), 64'(exp_fault));
        check(seen == hit, hit ? "R6" : tag, 64'(seen), 64'(hit));
        if (hit) check(maddr == pte, "R6", maddr, pte);
        else check(lat == 0, "R4", 64'(lat), 64'd0);
        check(ok_rdy, "R9", 64'(ok_rdy), 64'd1);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", 64'(req_ready), 64'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9: watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            finish_run();
        end
    end

    initial begin
        logic [63:0] d, a, base, mask;
        int sel;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 5; k++) sh[k] = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int k = 0; k < 5; k++) begin
            cfg_rd(12'h300 + 12'(k * 8), 1, d);
            check(d == 64'h0, "R1", d, 64'h0);
        end
        check(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R1", 64'(mem_req_valid), 64'd0);

        // R2: full-width access of every slot, unmapped offsets
        for (int k = 0; k < 5; k++) cfg_wr(12'h300 + 12'(k * 8), 1, {32'hC0DE_0000 + 32'(k), 32'h1357_9BDF});
        for (int k = 0; k < 5; k++) begin
            cfg_rd(12'h300 + 12'(k * 8), 1, d);
            check(d == exp_rd(12'h300 + 12'(k * 8), 1), "R2", d, exp_rd(12'h300 + 12'(k * 8), 1));
        end
        cfg_wr(12'h328, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_wr(12'h2F8, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_rd(12'h328, 1, d);
        check(d == 64'h0, "R2", d, 64'h0);
        cfg_rd(12'h2F8, 1, d);
        check(d == 64'h0, "R2", d, 64'h0);
        cfg_rd(12'h320, 1, d);
        check(d == sh[4], "R2", d, sh[4]);

        // R3: half access
        cfg_wr(12'h308, 1, 64'h1111_2222_3333_4444);
        cfg_wr(12'h30C, 0, 64'h5555_6666_AAAA_BBBB);
        cfg_rd(12'h308, 1, d);
        check(d == 64'hAAAA_BBBB_3333_4444, "R3", d, 64'hAAAA_BBBB_3333_4444);
        cfg_wr(12'h308, 0, 64'h0000_0000_0F0F_0F0F);
        cfg_rd(12'h308, 1, d);
        check(d == 64'hAAAA_BBBB_0F0F_0F0F, "R3", d, 64'hAAAA_BBBB_0F0F_0F0F);
        cfg_rd(12'h308, 0, d);
        check(d == 64'h0000_0000_0F0F_0F0F, "R3", d, 64'h0000_0000_0F0F_0F0F);
        cfg_rd(12'h30C, 0, d);
        check(d == 64'h0000_0000_AAAA_BBBB, "R3", d, 64'h0000_0000_AAAA_BBBB);

        // R4: disabled range
        cfg_wr(12'h300, 1, 64'h0000_0000_1234_5000);
        cfg_wr(12'h308, 1, 64'h0);
        xlate(64'h8123_4567_89AB_CDEF, "R4", 0);

        // R5: enabled, no match; also base with stray low bits never matches
        cfg_wr(12'h300, 1, 64'h0000_0000_4000_0001);
        cfg_wr(12'h308, 1, 64'hFFFF_FFFF_F000_0000);
        xlate(64'h0000_0000_5000_0ABC, "R5", 0);
        cfg_wr(12'h300, 1, 64'h0000_0000_4000_0003);
        xlate(64'h0000_0000_4000_0123, "R5", 0);

        // R7: valid entry with junk low bits
        cfg_wr(12'h300, 1, 64'h0000_0000_4000_0001);
        cfg_wr(12'h320, 1, 64'h0000_0001_0000_0000);
        use_ovr = 1; ovr = 64'h8000_0012_3456_7ABC;
        xlate(64'h0000_0000_4001_2FFF, "R7", 0);
        // R8: invalid entry
        ovr = 64'h7FFF_FFFF_FFFF_F000;
        xlate(64'h0000_0000_4003_4000, "R8", 0);
        // R6: directory address wraps modulo 2^64
        cfg_wr(12'h300, 1, 64'h1);
        cfg_wr(12'h308, 1, 64'h0);
        cfg_wr(12'h320, 1, 64'hFFFF_FFFF_FFFF_FFF8);
        ovr = 64'h8000_0000_0000_5000;
        xlate(64'h0000_0000_0000_3000, "R6", 0);
        // R10: base cleared while lookup outstanding
        ovr = 64'h8000_0000_0077_7000;
        xlate(64'h0000_0000_0000_9000, "R10", 1);
        use_ovr = 0;

        // Random mix
        for (int i = 0; i < 60; i++) begin
            a = {$urandom, $urandom};
            sel = int'($urandom % 4);
            mask = 64'hFFFF_FFFF_FFF0_0000;
            case (sel)
                0: base = a & mask;
                1: base = (a & mask) | 64'h1;
                2: base = ((a & mask) ^ 64'h0000_0000_0010_0000) | 64'h1;
                default: begin base = 64'h1; mask = 64'h0; end
            endcase
            set_reg(0, base);
            set_reg(1, mask);
            set_reg(4, {$urandom, $urandom} & ~64'h7);
            xlate(a, (sel == 0) ? "R4" : (sel == 2) ? "R5" : "R7", (i % 7) == 3);
        end

        done = 1;
        finish_run();
    end

endmodule